// File: doc/BRIEF.md
# Receive Buffer Latency Flush Timer

This block sits beside a receive byte FIFO that gathers incoming serial data on its way to a host. Short bursts of data would otherwise sit in the FIFO until a whole packet had built up. To prevent that, the block counts millisecond ticks from the most recent byte written. When the count reaches a host-set latency, it asks for the partial contents to be flushed. When the FIFO reports a full packet, it asks for a flush at once and does not wait for the timer.

The latency is an 8-bit whole number of milliseconds that the host writes at run time through a simple write port. The counter only advances while the FIFO holds data. Every new byte sends it back to zero, and so does every flush request. The millisecond time base is an external enable pulse one clock wide. The only output is a registered flush request one cycle wide.

Top module: `rx_flush_timer`

## Requirements
- R1: After reset, flush_req is low and the latency is 16 ms.
- R2: With no configuration write after reset, a byte write followed by 16 ticks, with the FIFO non-empty throughout, produces a flush. The first 15 ticks produce none.
- R3: A write of value N (1..255) on cfg_wdata with cfg_we high sets the latency to N ms. flush_req then goes high for exactly one cycle, in the cycle after the clock edge that samples the Nth tick counted since the last byte write.
- R4: After a timeout flush, if the FIFO stays non-empty, the counter restarts from zero and a further flush follows N ticks later.
- R5: A byte write sends the counter back to zero. When a byte write and a tick arrive in the same cycle, the byte write wins and the tick is not counted.
- R6: While fifo_nonempty is low, no timeout flush is made. A cycle with fifo_nonempty low also clears the count.
- R7: A written latency of 0 is stored as 1 ms, so the next tick after a byte causes a flush.
- R8: A latency of 255 flushes on the 255th tick and not before.
- R9: A rising edge on pkt_full gives a single flush in the next cycle, however long pkt_full stays high, and clears the counter.
- R10: The compare uses the current latency. If the latency is lowered to or below the ticks already counted, the next tick causes a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Host write strobe for the latency value |
| cfg_wdata | input | 8 | Latency in milliseconds (0 is treated as 1) |
| byte_wr | input | 1 | A byte was written into the receive FIFO this cycle |
| fifo_nonempty | input | 1 | Receive FIFO holds at least one byte |
| pkt_full | input | 1 | Receive FIFO holds a full packet |
| ms_tick | input | 1 | One-cycle millisecond enable pulse |
| flush_req | output | 1 | One-cycle registered flush request |

## Verification
The bench aims at the off-by-one edges of the count. If the compare were off by one, the flush would come a tick early or a tick late at the default of 16, at 1 and at 255. A zero write taken literally would never flush, or would wrap to 256 ticks. A byte arriving together with a tick is a trap for a design that lets the tick through: it would flush one tick early. Further cases cover a FIFO that briefly goes empty, a pkt_full held for several cycles, and a latency lowered below the elapsed count. A design that kept a stale count would flush early in the first case. A design that retriggered on the level of pkt_full, rather than its edge, would emit repeated pulses. A design that latched the old limit would flush late in the last case.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned RXF_LAT_W = 8;
  localparam int unsigned RXF_LAT_DEFAULT = 16;

  typedef enum logic [1:0] {
    FL_NONE    = 2'd0,
    FL_TIMEOUT = 2'd1,
    FL_PACKET  = 2'd2
  } flush_cause_e;
endpackage

// File: rtl/rxf_lat_reg.sv
module rxf_lat_reg #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lat_q
);
  localparam logic [W-1:0] MIN_LAT = W'(1);
  localparam logic [W-1:0] RST_LAT = W'(RST_VAL);

  logic [W-1:0] lat_d;

  always_comb begin
    lat_d = wdata;
    if (wdata == '0) lat_d = MIN_LAT;
  end

  always_ff @(posedge clk) begin
    if (rst) lat_q <= RST_LAT;
    else if (we) lat_q <= lat_d;
  end

  // R7
  lat_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    lat_q != '0);

  // R3
  lat_load_chk: assert property (@(posedge clk) disable iff (rst)
    (we && wdata != '0) |=> (lat_q == $past(wdata)));

  // R7
  lat_zero_load_chk: assert property (@(posedge clk) disable iff (rst)
    (we && wdata == '0) |=> (lat_q == MIN_LAT));
endmodule

// File: rtl/rxf_ms_counter.sv
module rxf_ms_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ms_tick,
  input  logic         byte_wr,
  input  logic         fifo_nonempty,
  input  logic         clear,
  input  logic [W-1:0] lat,
  output logic         expire,
  output logic [W-1:0] cnt_q
);
  logic [W:0] next_cnt;
  logic       restart;

  assign next_cnt = {1'b0, cnt_q} + (W+1)'(1);
  assign restart  = clear | byte_wr | ~fifo_nonempty;

  always_comb begin
    expire = 1'b0;
    if (fifo_nonempty && !byte_wr && ms_tick)
      expire = (next_cnt >= {1'b0, lat});
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (ms_tick) cnt_q <= next_cnt[W-1:0];
  end

  // R5
  byte_restart_chk: assert property (@(posedge clk) disable iff (rst)
    byte_wr |=> (cnt_q == '0));

  // R6
  empty_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !fifo_nonempty |=> (cnt_q == '0));

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q != '1);

  // R6
  empty_no_expire_chk: assert property (@(posedge clk) disable iff (rst)
    !fifo_nonempty |-> !expire);
endmodule

// File: rtl/rxf_flush_ctrl.sv
module rxf_flush_ctrl
  import rxf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pkt_full,
  input  logic expire,
  output logic fire,
  output logic flush_req
);
  logic         pkt_d;
  logic         pkt_rise;
  flush_cause_e cause;

  assign pkt_rise = pkt_full & ~pkt_d;

  always_comb begin
    cause = FL_NONE;
    if (pkt_rise)    cause = FL_PACKET;
    else if (expire) cause = FL_TIMEOUT;
  end

  assign fire = (cause != FL_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_d     <= 1'b0;
      flush_req <= 1'b0;
    end else begin
      pkt_d     <= pkt_full;
      flush_req <= fire;
    end
  end

  // R9
  pkt_flush_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pkt_full) |=> flush_req);

  // R3
  timeout_flush_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> flush_req);

  // R9
  pkt_held_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_full && pkt_d && !expire) |=> !flush_req);
endmodule

// File: rtl/rx_flush_timer.sv
module rx_flush_timer
  import rxf_pkg::*;
#(
  parameter int unsigned LAT_W   = RXF_LAT_W,
  parameter int unsigned LAT_RST = RXF_LAT_DEFAULT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [LAT_W-1:0] cfg_wdata,
  input  logic             byte_wr,
  input  logic             fifo_nonempty,
  input  logic             pkt_full,
  input  logic             ms_tick,
  output logic             flush_req
);
  logic [LAT_W-1:0] lat_q;
  logic [LAT_W-1:0] cnt_q;
  logic             expire;
  logic             fire;

  rxf_lat_reg #(.W(LAT_W), .RST_VAL(LAT_RST)) u_lat (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .lat_q (lat_q)
  );

  rxf_ms_counter #(.W(LAT_W)) u_cnt (
    .clk           (clk),
    .rst           (rst),
    .ms_tick       (ms_tick),
    .byte_wr       (byte_wr),
    .fifo_nonempty (fifo_nonempty),
    .clear         (fire),
    .lat           (lat_q),
    .expire        (expire),
    .cnt_q         (cnt_q)
  );

  rxf_flush_ctrl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .pkt_full  (pkt_full),
    .expire    (expire),
    .fire      (fire),
    .flush_req (flush_req)
  );

  // R10
  lowered_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (ms_tick && fifo_nonempty && !byte_wr && cnt_q >= lat_q) |=> flush_req);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !flush_req);
endmodule

// File: tb/sim_rx_flush_timer.sv
module sim_rx_flush_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       byte_wr = 1'b0;
  logic       fifo_nonempty = 1'b0;
  logic       pkt_full = 1'b0;
  logic       ms_tick = 1'b0;
  logic       flush_req;

  int    cyc = 0;
  int    total = 0;
  int    fails = 0;
  bit    mon_on = 1'b0;
  bit    done = 1'b0;
  string phase = "R1";
  int    exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rx_flush_timer u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .byte_wr(byte_wr), .fifo_nonempty(fifo_nonempty), .pkt_full(pkt_full),
    .ms_tick(ms_tick), .flush_req(flush_req)
  );

  // monitor: pops expected flush cycles and compares with observed pulses
  always @(negedge clk) begin
    if (mon_on) begin
      while (exp_q.size() > 0 && exp_q[0] < cyc) begin
        total++; fails++;
        $display("FAIL %s: flush_req actual=0 expected=1 at cycle %0d", tag_q[0], exp_q[0]);
        void'(exp_q.pop_front()); void'(tag_q.pop_front());
      end
      if (flush_req) begin
        total++;
        if (exp_q.size() > 0 && exp_q[0] == cyc) begin
          void'(exp_q.pop_front()); void'(tag_q.pop_front());
        end else begin
          fails++;
          $display("FAIL %s: flush_req actual=1 expected=0 at cycle %0d", phase, cyc);
        end
      end
    end
  end

  task automatic expect_at(int c, string tag);
    exp_q.push_back(c); tag_q.push_back(tag);
  endtask

  task automatic tick(bit exp, string tag);
    @(negedge clk); ms_tick = 1'b1; phase = tag;
    if (exp) expect_at(cyc + 1, tag);
    @(negedge clk); ms_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic ticks_quiet(int n, string tag);
    for (int i = 0; i < n; i++) tick(1'b0, tag);
  endtask

  task automatic wr_byte();
    @(negedge clk); byte_wr = 1'b1; fifo_nonempty = 1'b1;
    @(negedge clk); byte_wr = 1'b0;
  endtask

  task automatic wr_cfg(logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (flush_req !== 1'b0) begin
      fails++; $display("FAIL R1: flush_req actual=%b expected=0 after reset", flush_req);
    end
    mon_on = 1'b1;

    // R1 / R2: default latency of 16
    wr_byte();
    ticks_quiet(15, "R2");
    tick(1'b1, "R2");

    // R3: latency 3, one-cycle pulse
    wr_cfg(8'd3);
    wr_byte();
    ticks_quiet(2, "R3");
    tick(1'b1, "R3");
    // R4: FIFO still holds data, counter restarts after flush
    ticks_quiet(2, "R4");
    tick(1'b1, "R4");

    // R5: byte write restarts the count
    wr_cfg(8'd4);
    wr_byte();
    ticks_quiet(3, "R5");
    wr_byte();
    ticks_quiet(3, "R5");
    tick(1'b1, "R5");
    // R5: byte write and tick in the same cycle, byte wins
    wr_cfg(8'd2);
    wr_byte();
    tick(1'b0, "R5");
    @(negedge clk); byte_wr = 1'b1; ms_tick = 1'b1; phase = "R5";
    @(negedge clk); byte_wr = 1'b0; ms_tick = 1'b0;
    tick(1'b0, "R5");
    tick(1'b1, "R5");

    // R6: empty FIFO never flushes
    wr_cfg(8'd4);
    @(negedge clk); fifo_nonempty = 1'b0;
    ticks_quiet(10, "R6");
    // R6: brief empty clears the count
    wr_byte();
    ticks_quiet(3, "R6");
    @(negedge clk); fifo_nonempty = 1'b0;
    @(negedge clk); fifo_nonempty = 1'b1;
    ticks_quiet(3, "R6");
    tick(1'b1, "R6");

    // R7: zero is treated as one
    wr_cfg(8'd0);
    wr_byte();
    tick(1'b1, "R7");
    tick(1'b1, "R7");

    // R9: rising edge of pkt_full, held for several cycles
    wr_cfg(8'd5);
    wr_byte();
    ticks_quiet(3, "R9");
    @(negedge clk); pkt_full = 1'b1; phase = "R9";
    expect_at(cyc + 1, "R9");
    repeat (4) @(negedge clk);
    pkt_full = 1'b0;
    ticks_quiet(4, "R9");
    tick(1'b1, "R9");

    // R10: lowering the latency below the elapsed count
    wr_cfg(8'd10);
    wr_byte();
    ticks_quiet(5, "R10");
    wr_cfg(8'd3);
    tick(1'b1, "R10");

    // R8: maximum latency
    wr_cfg(8'd255);
    wr_byte();
    ticks_quiet(254, "R8");
    tick(1'b1, "R8");

    phase = "R6";
    @(negedge clk); fifo_nonempty = 1'b0;
    repeat (10) @(negedge clk);
    mon_on = 1'b0;
    while (exp_q.size() > 0) begin
      total++; fails++;
      $display("FAIL %s: flush_req actual=0 expected=1 at cycle %0d", tag_q[0], exp_q[0]);
      void'(exp_q.pop_front()); void'(tag_q.pop_front());
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; fails++;
      $display("FAIL R3: watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule